// File: doc/BRIEF.md
# Page-Tag Packet Transmitter

This block sends one packet at a time onto a byte-wide link. Software describes the packet as a series of page tags. Each tag carries a start word address, a count of valid words (1 to 64) and a flag that marks the final page of the packet. Pages may sit anywhere in memory and may be partly filled. The engine reads each word through a single read port with a fixed latency of one cycle. It shifts each word onto the link one byte per accepted handshake.

While words are fetched, a 32-bit CRC is built over the packet. The first tag of a packet can name a number of leading words to keep out of the CRC, so that a header rewritten along the route does not break the checksum. After the last data word the engine sends a word taken from a free-running cycle counter, and then the CRC word. A one-cycle pulse reports the end of each page together with that page's address, and a second pulse reports the end of the packet. If the next tag is late in the middle of a packet, the engine waits and sends nothing.

Top module: `pkt_tx_engine`

## Requirements
- R1: After reset `tag_ready_o` is 1, and `link_valid_o`, `mem_req_o`, `evt_page_o` and `evt_pkt_o` are 0.
- R2: For each tag, words are read from addresses `addr`, `addr+1`, ..., `addr+count-1`, where `count` is 1 to 64 in a 7-bit field. Each word is sent as four link bytes, bits 31:24 first and bits 7:0 last.
- R3: While `link_valid_o` is 1 and `link_ready_i` is 0, the next cycle keeps `link_valid_o` at 1 and keeps `link_byte_o` unchanged. A byte is transferred only in a cycle where both are 1.
- R4: Pages are sent in the order of their tags, and the address of each page comes only from its own tag.
- R5: The CRC word follows the polynomial 0x04C11DB7 with a preset of 0xFFFFFFFF. Each word is fed in from bit 31 down to bit 0, the result is not inverted, and it is sent as the final word of the packet.
- R6: The timestamp word equals the value of a 32-bit counter in the cycle where its first byte first appears on the link. The counter is 0 in the first cycle after reset and rises by 1 every cycle.
- R7: A packet on the link is all data words, then the timestamp word, then the CRC word, with no other bytes.
- R8: `evt_page_o` pulses for one cycle, exactly one cycle after the handshake of the final byte of a page. In that cycle `evt_addr_o` holds the page's tag address.
- R9: `evt_pkt_o` pulses for one cycle, exactly one cycle after the handshake of the final CRC byte.
- R10: If a non-final page is done and no tag is offered, `link_valid_o` and `mem_req_o` stay 0 and `tag_ready_o` stays 1 until a tag is accepted.
- R11: `mem_req_o` is high for single cycles only. It is never high while a byte is pending on the link, and the word is taken from `mem_rdata_i` in the cycle after the request.
- R12: The skip count of the packet's first tag leaves that many leading packet words out of the CRC, and the skip may reach into later pages. The skip field of any later tag has no effect on the CRC.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tag_valid_i | input | 1 | A page tag is offered |
| tag_ready_o | output | 1 | The engine accepts a tag this cycle |
| tag_addr_i | input | AW | Word address of the page start |
| tag_count_i | input | CW | Valid words on the page (1 to 64) |
| tag_skip_i | input | CW | Leading packet words left out of the CRC (first tag only) |
| tag_last_i | input | 1 | This is the final page of the packet |
| mem_req_o | output | 1 | Read request |
| mem_addr_o | output | AW | Read word address |
| mem_rdata_i | input | 32 | Read data, valid the cycle after the request |
| link_valid_o | output | 1 | A byte is presented on the link |
| link_ready_i | input | 1 | The link takes the byte |
| link_byte_o | output | 8 | Link byte |
| evt_page_o | output | 1 | Page-done pulse |
| evt_pkt_o | output | 1 | Packet-done pulse |
| evt_addr_o | output | AW | Address of the finished page |

## Verification
A read word shows up as its first link byte one cycle after the read data cycle. A page or packet event is due exactly one cycle after the handshake of the closing byte. The timestamp must match the bench's own cycle count at the first appearance of its leading byte. The bench samples every output on the falling clock edge. For each byte it records the cycle of first appearance and the cycle of the handshake, so every event and the timestamp are compared against the exact cycle they are due, not only checked for order. Backpressure from a pseudo-random ready pattern checks that results stay correct when they are delayed.

// File: rtl/pkt_tx_pkg.sv
package pkt_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_TAG, ST_REQ, ST_DATA, ST_SEND, ST_TS, ST_CRC, ST_TAIL
  } st_e;

  localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;
  localparam logic [31:0] CRC_INIT = 32'hFFFF_FFFF;
endpackage

// File: rtl/pkt_tx_crc32.sv
module pkt_tx_crc32 (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        upd_i,
  input  logic [31:0] data_i,
  output logic [31:0] crc_o
);
  import pkt_tx_pkg::*;

  logic [31:0] acc_q, acc_d;

  always_comb begin
    acc_d = acc_q;
    for (int i = 31; i >= 0; i--) begin
      if (acc_d[31] ^ data_i[i]) acc_d = {acc_d[30:0], 1'b0} ^ CRC_POLY;
      else                       acc_d = {acc_d[30:0], 1'b0};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= CRC_INIT;
    else if (clr_i) acc_q <= CRC_INIT;
    else if (upd_i) acc_q <= acc_d;
  end

  assign crc_o = acc_q;
endmodule

// File: rtl/pkt_tx_stamp.sv
module pkt_tx_stamp #(
  parameter int unsigned TW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [TW-1:0] now_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) now_o <= '0;
    else         now_o <= now_o + TW'(1);
  end
endmodule

// File: rtl/pkt_tx_ser.sv
module pkt_tx_ser #(
  parameter int unsigned WW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [WW-1:0] word_i,
  input  logic          ready_i,
  output logic          valid_o,
  output logic [7:0]    byte_o,
  output logic          done_o
);
  localparam int unsigned NB  = WW / 8;
  localparam int unsigned BIW = (NB > 1) ? $clog2(NB) : 1;
  localparam logic [BIW-1:0] LAST_B = BIW'(NB - 1);

  logic [WW-1:0]  sh_q;
  logic [BIW-1:0] idx_q;
  logic           busy_q;

  assign valid_o = busy_q;
  assign byte_o  = sh_q[WW-1 -: 8];
  assign done_o  = busy_q && ready_i && (idx_q == LAST_B);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      idx_q  <= '0;
      busy_q <= 1'b0;
    end else if (load_i) begin
      sh_q   <= word_i;
      idx_q  <= '0;
      busy_q <= 1'b1;
    end else if (busy_q && ready_i) begin
      sh_q  <= sh_q << 8;
      idx_q <= idx_q + BIW'(1);
      if (idx_q == LAST_B) busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/pkt_tx_engine.sv
module pkt_tx_engine #(
  parameter int unsigned AW        = 16,
  parameter int unsigned MAX_WORDS = 64,
  parameter int unsigned CW        = $clog2(MAX_WORDS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tag_valid_i,
  output logic          tag_ready_o,
  input  logic [AW-1:0] tag_addr_i,
  input  logic [CW-1:0] tag_count_i,
  input  logic [CW-1:0] tag_skip_i,
  input  logic          tag_last_i,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic [31:0]   mem_rdata_i,
  output logic          link_valid_o,
  input  logic          link_ready_i,
  output logic [7:0]    link_byte_o,
  output logic          evt_page_o,
  output logic          evt_pkt_o,
  output logic [AW-1:0] evt_addr_o
);
  import pkt_tx_pkg::*;

  st_e           st_q;
  logic [AW-1:0] base_q;
  logic [CW-1:0] cnt_q, idx_q, skip_q;
  logic          last_q, tail_crc_q;
  logic          evt_page_q, evt_pkt_q;
  logic [AW-1:0] evt_addr_q;

  logic          ser_load, ser_done;
  logic [31:0]   ser_word, crc_val, now_val;
  logic          crc_clr, crc_upd;
  logic          take_tag;

  pkt_tx_stamp #(.TW(32)) u_stamp (
    .clk_i (clk_i), .rst_ni(rst_ni), .now_o(now_val)
  );

  pkt_tx_crc32 u_crc (
    .clk_i (clk_i), .rst_ni(rst_ni), .clr_i(crc_clr), .upd_i(crc_upd),
    .data_i(mem_rdata_i), .crc_o(crc_val)
  );

  pkt_tx_ser #(.WW(32)) u_ser (
    .clk_i  (clk_i),       .rst_ni (rst_ni),
    .load_i (ser_load),    .word_i (ser_word),
    .ready_i(link_ready_i),.valid_o(link_valid_o),
    .byte_o (link_byte_o), .done_o (ser_done)
  );

  assign tag_ready_o = (st_q == ST_IDLE) || (st_q == ST_TAG);
  assign take_tag    = tag_ready_o && tag_valid_i;
  assign mem_req_o   = (st_q == ST_REQ);
  assign mem_addr_o  = base_q + AW'(idx_q);
  assign crc_clr     = take_tag && (st_q == ST_IDLE);
  assign crc_upd     = (st_q == ST_DATA) && (skip_q == '0);

  always_comb begin
    ser_load = 1'b0;
    ser_word = mem_rdata_i;
    unique case (st_q)
      ST_DATA: ser_load = 1'b1;
      // stamp is the counter value when the first byte becomes visible
      ST_TS:   begin ser_load = 1'b1; ser_word = now_val + 32'd1; end
      ST_CRC:  begin ser_load = 1'b1; ser_word = crc_val; end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      base_q     <= '0;
      cnt_q      <= '0;
      idx_q      <= '0;
      skip_q     <= '0;
      last_q     <= 1'b0;
      tail_crc_q <= 1'b0;
      evt_page_q <= 1'b0;
      evt_pkt_q  <= 1'b0;
      evt_addr_q <= '0;
    end else begin
      evt_page_q <= 1'b0;
      evt_pkt_q  <= 1'b0;
      unique case (st_q)
        ST_IDLE, ST_TAG: begin
          if (tag_valid_i) begin
            base_q <= tag_addr_i;
            cnt_q  <= tag_count_i;
            last_q <= tag_last_i;
            idx_q  <= '0;
            if (st_q == ST_IDLE) skip_q <= tag_skip_i;
            st_q   <= ST_REQ;
          end
        end
        ST_REQ:  st_q <= ST_DATA;
        ST_DATA: begin
          if (skip_q != '0) skip_q <= skip_q - CW'(1);
          st_q <= ST_SEND;
        end
        ST_SEND: begin
          if (ser_done) begin
            if (idx_q == cnt_q - CW'(1)) begin
              evt_page_q <= 1'b1;
              evt_addr_q <= base_q;
              st_q       <= last_q ? ST_TS : ST_TAG;
            end else begin
              idx_q <= idx_q + CW'(1);
              st_q  <= ST_REQ;
            end
          end
        end
        ST_TS: begin
          tail_crc_q <= 1'b0;
          st_q       <= ST_TAIL;
        end
        ST_CRC: begin
          tail_crc_q <= 1'b1;
          st_q       <= ST_TAIL;
        end
        ST_TAIL: begin
          if (ser_done) begin
            if (tail_crc_q) begin
              evt_pkt_q <= 1'b1;
              st_q      <= ST_IDLE;
            end else begin
              st_q <= ST_CRC;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign evt_page_o = evt_page_q;
  assign evt_pkt_o  = evt_pkt_q;
  assign evt_addr_o = evt_addr_q;
endmodule

// File: rtl/pkt_tx_chk.sv
module pkt_tx_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tag_ready_o,
  input logic       mem_req_o,
  input logic       link_valid_o,
  input logic       link_ready_i,
  input logic [7:0] link_byte_o,
  input logic       evt_page_o,
  input logic       evt_pkt_o
);
  AST_BYTE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_valid_o && !link_ready_i |=> link_valid_o && $stable(link_byte_o)); // R3

  AST_REQ_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o); // R11

  AST_REQ_LINK_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !link_valid_o); // R11

  AST_PAGE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_page_o |=> !evt_page_o); // R8

  AST_PKT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_pkt_o |=> !evt_pkt_o); // R9

  AST_WAIT_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tag_ready_o |-> !link_valid_o && !mem_req_o); // R10
endmodule

bind pkt_tx_engine pkt_tx_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tag_ready_o (tag_ready_o),
  .mem_req_o   (mem_req_o),
  .link_valid_o(link_valid_o),
  .link_ready_i(link_ready_i),
  .link_byte_o (link_byte_o),
  .evt_page_o  (evt_page_o),
  .evt_pkt_o   (evt_pkt_o)
);

// File: tb/pkt_tx_engine_tb_top.sv
`timescale 1ns/1ps
module pkt_tx_engine_tb_top;
  localparam int AW = 16;
  localparam int CW = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tag_valid = 1'b0;
  logic          tag_ready;
  logic [AW-1:0] tag_addr = '0;
  logic [CW-1:0] tag_count = '0;
  logic [CW-1:0] tag_skip = '0;
  logic          tag_last = 1'b0;
  logic          mem_req;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_rdata;
  logic          link_valid;
  logic          link_ready;
  logic [7:0]    link_byte;
  logic          evt_page, evt_pkt;
  logic [AW-1:0] evt_addr;

  always #10 clk = ~clk;

  pkt_tx_engine dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .tag_valid_i(tag_valid), .tag_ready_o(tag_ready), .tag_addr_i(tag_addr),
    .tag_count_i(tag_count), .tag_skip_i(tag_skip), .tag_last_i(tag_last),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata),
    .link_valid_o(link_valid), .link_ready_i(link_ready), .link_byte_o(link_byte),
    .evt_page_o(evt_page), .evt_pkt_o(evt_pkt), .evt_addr_o(evt_addr)
  );

  int tests = 0, fails = 0;

  function automatic logic [31:0] memf(input int a);
    logic [31:0] x;
    x = 32'(a) & 32'h0000_FFFF;
    return (x * 32'h9E37_79B1) ^ 32'h5A5A_0F0F ^ (x << 7);
  endfunction

  function automatic logic [31:0] crc_w(input logic [31:0] c, input logic [31:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 31; i >= 0; i--) begin
      logic fb;
      fb = r[31] ^ d[i];
      r = r << 1;
      if (fb) r = r ^ 32'h04C1_1DB7;
    end
    return r;
  endfunction

  // memory: one-cycle read latency
  always_ff @(posedge clk) if (mem_req) mem_rdata <= memf(int'(mem_addr));

  int cyc;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  int  rmode = 0;
  logic [7:0] lf = 8'hA5;
  initial begin
    link_ready = 1'b0;
    forever begin
      @(posedge clk); #3;
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      link_ready = (rmode == 0) ? 1'b1 : lf[0];
    end
  end

  // link / event collector
  logic [7:0] b_log [0:1023];
  int  st_log [0:1023];
  int  hs_log [0:1023];
  int  n_bytes = 0, n_pg = 0, n_pkt = 0, pkt_cyc = 0, cur_start = 0;
  bit  in_byte = 0;
  int  pg_cyc [0:7];
  logic [AW-1:0] pg_evaddr [0:7];

  always @(negedge clk) begin
    if (rst_n) begin
      if (link_valid && !in_byte) begin in_byte = 1; cur_start = cyc; end
      if (link_valid && link_ready && n_bytes < 1024) begin
        b_log[n_bytes] = link_byte; st_log[n_bytes] = cur_start;
        hs_log[n_bytes] = cyc; n_bytes++; in_byte = 0;
      end
      if (evt_page && n_pg < 8) begin pg_cyc[n_pg] = cyc; pg_evaddr[n_pg] = evt_addr; n_pg++; end
      if (evt_pkt) begin pkt_cyc = cyc; n_pkt++; end
    end
  end

  task automatic chk(input bit ok, input string rq, input string msg,
                     input longint act, input longint expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", rq, msg, act, expv);
    end
  endtask

  int pg_addr [0:3];
  int pg_cnt  [0:3];
  int pg_skip [0:3];

  task automatic send_tag(input int a, input int c, input int s, input bit l);
    @(negedge clk);
    tag_valid = 1'b1; tag_addr = AW'(a); tag_count = CW'(c);
    tag_skip = CW'(s); tag_last = l;
    #1;
    while (!tag_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    tag_valid = 1'b0;
  endtask

  task automatic run_pkt(input int npg, input int gap, input string nm);
    logic [7:0] e [0:1023];
    int nw, g, tmo, bad, first_bad, endb;
    logic [31:0] crc, w, tsv, gotc;
    n_bytes = 0; n_pg = 0; n_pkt = 0; in_byte = 0;
    for (int p = 0; p < npg; p++) begin
      send_tag(pg_addr[p], pg_cnt[p], pg_skip[p], p == npg - 1);
      if (p == 0 && gap > 0) begin
        tmo = 0;
        while (n_pg < 1 && tmo < 5000) begin @(negedge clk); tmo++; end
        bad = 0;
        for (int i = 0; i < gap; i++) begin
          @(negedge clk); #1;
          if (link_valid || mem_req || !tag_ready) bad++;
        end
        chk(bad == 0, "R10", {nm, " silent while waiting for tag"}, bad, 0);
        chk(n_bytes == pg_cnt[0] * 4, "R10", {nm, " bytes before stall"}, n_bytes, pg_cnt[0] * 4);
      end
    end
    tmo = 0;
    while (n_pkt < 1 && tmo < 5000) begin @(negedge clk); tmo++; end
    @(negedge clk); @(negedge clk);

    nw = 0; g = 0; crc = 32'hFFFF_FFFF;
    for (int p = 0; p < npg; p++)
      for (int i = 0; i < pg_cnt[p]; i++) begin
        w = memf(pg_addr[p] + i);
        for (int k = 0; k < 4; k++) e[nw * 4 + k] = w[31 - 8 * k -: 8];
        if (g >= pg_skip[0]) crc = crc_w(crc, w);
        g++; nw++;
      end

    chk(n_bytes == nw * 4 + 8, "R7", {nm, " byte count"}, n_bytes, nw * 4 + 8);
    if (n_bytes == nw * 4 + 8) begin
      bad = 0; first_bad = -1;
      for (int i = 0; i < nw * 4; i++)
        if (b_log[i] !== e[i]) begin bad++; if (first_bad < 0) first_bad = i; end
      chk(bad == 0, "R2", {nm, " data bytes (R4 page order)"},
          first_bad < 0 ? 0 : b_log[first_bad], first_bad < 0 ? 0 : e[first_bad]);
      tsv  = {b_log[nw*4], b_log[nw*4+1], b_log[nw*4+2], b_log[nw*4+3]};
      chk(tsv == 32'(st_log[nw*4]), "R6", {nm, " timestamp"}, tsv, st_log[nw*4]);
      gotc = {b_log[nw*4+4], b_log[nw*4+5], b_log[nw*4+6], b_log[nw*4+7]};
      chk(gotc == crc, "R5", {nm, " crc (R12 skip)"}, gotc, crc);
      chk(pkt_cyc == hs_log[nw*4+7] + 1, "R9", {nm, " packet event cycle"}, pkt_cyc, hs_log[nw*4+7] + 1);
    end
    chk(n_pkt == 1, "R9", {nm, " packet event count"}, n_pkt, 1);
    chk(n_pg == npg, "R8", {nm, " page event count"}, n_pg, npg);
    if (n_pg == npg && n_bytes >= nw * 4) begin
      bad = 0; endb = 0;
      for (int p = 0; p < npg; p++) begin
        endb += pg_cnt[p] * 4;
        if (pg_evaddr[p] != AW'(pg_addr[p]) || pg_cyc[p] != hs_log[endb - 1] + 1) bad++;
      end
      chk(bad == 0, "R8", {nm, " page event address and cycle"}, bad, 0);
    end
  endtask

  task automatic t_reset();
    @(negedge clk); #1;
    chk(tag_ready == 1'b1, "R1", "tag_ready after reset", tag_ready, 1);
    chk({link_valid, mem_req, evt_page, evt_pkt} == 4'b0, "R1", "outputs idle after reset",
        {link_valid, mem_req, evt_page, evt_pkt}, 0);
  endtask

  task automatic t_single();
    rmode = 0;
    pg_addr[0] = 'h40; pg_cnt[0] = 5; pg_skip[0] = 0;
    run_pkt(1, 0, "single");
  endtask

  task automatic t_multi();
    rmode = 1;
    pg_addr[0] = 'h100; pg_cnt[0] = 3;  pg_skip[0] = 2;
    pg_addr[1] = 'h020; pg_cnt[1] = 64; pg_skip[1] = 5;  // R12 ignored
    pg_addr[2] = 'h300; pg_cnt[2] = 1;  pg_skip[2] = 9;
    run_pkt(3, 0, "multi_backpressure R3 R4");
  endtask

  task automatic t_stall();
    rmode = 1;
    pg_addr[0] = 'h200; pg_cnt[0] = 2; pg_skip[0] = 1;
    pg_addr[1] = 'h210; pg_cnt[1] = 3; pg_skip[1] = 0;
    run_pkt(2, 25, "stall");
  endtask

  task automatic t_skip_all();
    rmode = 0;
    pg_addr[0] = 'h10; pg_cnt[0] = 4; pg_skip[0] = 4;
    run_pkt(1, 0, "skip_all");
  endtask

  task automatic t_skip_span();
    rmode = 1;
    pg_addr[0] = 'h10; pg_cnt[0] = 2; pg_skip[0] = 3;
    pg_addr[1] = 'h50; pg_cnt[1] = 2; pg_skip[1] = 0;
    run_pkt(2, 0, "skip_span R12");
  endtask

  bit done = 0;
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_single();
    t_multi();
    t_stall();
    t_skip_all();
    t_skip_span();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(64'd200000 * 20);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule